// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Zero Suppression

This block turns one 4-bit BCD digit into the seven drive lines of a seven-segment display. A parameter sets the output polarity. It can drive displays with a shared cathode, where a lit segment is 1, or displays with a shared anode, where a lit segment is 0. The block is purely combinational and holds no state.

Three controls sit on top of the digit lookup, in this order of precedence:

- A forced-blank input turns the display off.
- A lamp-test input lights every segment.
- A ripple-suppress input blanks a zero digit and passes the suppression on to the next digit through `suppress_o`.

Several copies can be chained from the most significant digit down. Each copy takes its `suppress_i` from the `suppress_o` of the digit above it, and the first copy has its input held high. In this chain, leading zeros go dark while embedded and trailing zeros stay lit. The least significant digit has its suppress input tied low, so a value of zero still shows one 0.

Top module: `bcd7_decoder`

## Requirements
- R1: With `ACTIVE_LOW`=0 and no control active, `seg_o` bits [6:0] carry segments a..g. The patterns are:

  | Digit | a..g | Digit | a..g |
  |---|---|---|---|
  | 0 | 1111110 | 5 | 1011011 |
  | 1 | 0110000 | 6 | 1011111 |
  | 2 | 1101101 | 7 | 1110000 |
  | 3 | 1111001 | 8 | 1111111 |
  | 4 | 0110011 | 9 | 1111011 |

- R2: Codes 10 to 15 drive every segment off and leave `suppress_o` low.
- R3: With `ACTIVE_LOW`=1, every `seg_o` bit is the inverse of the active-high result for the same inputs.
- R4: While `lamp_test_i`=1 and `blank_ni`=1, all seven segments are on, for any `bcd_i`, including invalid codes.
- R5: While `blank_ni`=0, all segments are off and `suppress_o`=0. This holds whatever `lamp_test_i`, `suppress_i` and `bcd_i` are.
- R6: `suppress_i`=1 with `bcd_i`=0, `lamp_test_i`=0 and `blank_ni`=1 blanks the digit and drives `suppress_o`=1.
- R7: A nonzero valid digit with `suppress_i`=1 shows its normal pattern and drives `suppress_o`=0.
- R8: A zero digit with `suppress_i`=0 shows the 0 pattern, and `suppress_o`=0.
- R9: Lamp test outranks ripple suppression. A zero digit with `suppress_i`=1 and `lamp_test_i`=1 shows all segments on, with `suppress_o`=0.
- R10: In a five-digit chain, each digit's `suppress_i` comes from the next more significant digit's `suppress_o`. The most significant digit has `suppress_i`=1 and the least significant has `suppress_i`=0. With this wiring, every leading zero is blank, all other digits show, and 00000 shows only a final 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_i | input | 4 | BCD digit to display |
| lamp_test_i | input | 1 | 1 lights all segments |
| blank_ni | input | 1 | 0 forces the digit dark |
| suppress_i | input | 1 | Ripple suppression from the more significant digit |
| seg_o | output | 7 | Segment drive, bit 6 = a through bit 0 = g |
| suppress_o | output | 1 | Ripple suppression to the less significant digit |

## Verification
The hardest case to reach is ripple suppression stopping partway along a chain. It needs several digits wired together, with a run of zeros followed by a nonzero digit and then more zeros. The bench builds a five-digit chain from the block's own ports. It applies values such as 01234, 00700, 00000 and 10000, then checks each digit's segments. This confirms that only leading zeros go dark and that the tied-low last digit still shows 0.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  localparam int DIG_W = 4;
  localparam int SEG_W = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [DIG_W-1:0] dig_t;
  typedef logic [SEG_W-1:0] seg_t;

  typedef enum logic [1:0] {
    DISP_SHOW = 2'd0,
    DISP_ON   = 2'd1,
    DISP_OFF  = 2'd2
  } disp_e;
endpackage

// File: rtl/bcd7_pattern.sv
module bcd7_pattern
  import bcd7_pkg::*;
(
  input  dig_t bcd_i,
  output seg_t seg_o,
  output logic valid_o,
  output logic zero_o
);
  // active-high pattern, bit 6 = a ... bit 0 = g
  always_comb begin
    unique case (bcd_i)
      4'd0:    seg_o = 7'b1111110;
      4'd1:    seg_o = 7'b0110000;
      4'd2:    seg_o = 7'b1101101;
      4'd3:    seg_o = 7'b1111001;
      4'd4:    seg_o = 7'b0110011;
      4'd5:    seg_o = 7'b1011011;
      4'd6:    seg_o = 7'b1011111;
      4'd7:    seg_o = 7'b1110000;
      4'd8:    seg_o = 7'b1111111;
      4'd9:    seg_o = 7'b1111011;
      default: seg_o = '0;
    endcase
  end

  assign valid_o = (bcd_i <= dig_t'(MAX_DIGIT));
  assign zero_o  = (bcd_i == '0);
endmodule

// File: rtl/bcd7_blank_ctrl.sv
module bcd7_blank_ctrl
  import bcd7_pkg::*;
(
  input  logic  zero_i,
  input  logic  valid_i,
  input  logic  lamp_test_i,
  input  logic  blank_ni,
  input  logic  suppress_i,
  output disp_e mode_o,
  output logic  suppress_o
);
  // precedence: forced blank > lamp test > invalid code > ripple zero
  always_comb begin
    mode_o     = DISP_SHOW;
    suppress_o = 1'b0;
    if (!blank_ni) begin
      mode_o = DISP_OFF;
    end else if (lamp_test_i) begin
      mode_o = DISP_ON;
    end else if (!valid_i) begin
      mode_o = DISP_OFF;
    end else if (suppress_i && zero_i) begin
      mode_o     = DISP_OFF;
      suppress_o = 1'b1;
    end
  end
endmodule

// File: rtl/bcd7_polarity.sv
module bcd7_polarity
  import bcd7_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  seg_t seg_i,
  output seg_t seg_o
);
  if (ACTIVE_LOW) begin : g_inv
    assign seg_o = ~seg_i;
  end else begin : g_pass
    assign seg_o = seg_i;
  end
endmodule

// File: rtl/bcd7_decoder.sv
module bcd7_decoder
  import bcd7_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [3:0] bcd_i,
  input  logic       lamp_test_i,
  input  logic       blank_ni,
  input  logic       suppress_i,
  output logic [6:0] seg_o,
  output logic       suppress_o
);
  seg_t  pat;
  seg_t  seg_hi;
  logic  valid;
  logic  zero;
  disp_e mode;

  bcd7_pattern u_pat (
    .bcd_i   (bcd_i),
    .seg_o   (pat),
    .valid_o (valid),
    .zero_o  (zero)
  );

  bcd7_blank_ctrl u_ctrl (
    .zero_i      (zero),
    .valid_i     (valid),
    .lamp_test_i (lamp_test_i),
    .blank_ni    (blank_ni),
    .suppress_i  (suppress_i),
    .mode_o      (mode),
    .suppress_o  (suppress_o)
  );

  always_comb begin
    unique case (mode)
      DISP_ON:  seg_hi = '1;
      DISP_OFF: seg_hi = '0;
      default:  seg_hi = pat;
    endcase
  end

  bcd7_polarity #(.ACTIVE_LOW(ACTIVE_LOW)) u_pol (
    .seg_i (seg_hi),
    .seg_o (seg_o)
  );
endmodule

// File: rtl/bcd7_decoder_chk.sv
module bcd7_decoder_chk #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input logic [3:0] bcd_i,
  input logic       lamp_test_i,
  input logic       blank_ni,
  input logic       suppress_i,
  input logic [6:0] seg_o,
  input logic       suppress_o
);
  logic [6:0] lit;
  assign lit = ACTIVE_LOW ? ~seg_o : seg_o;

  always_comb begin
    // R5
    forced_blank_chk: assert (blank_ni || (lit == 7'd0 && !suppress_o))
      else $error("forced blank violated");
    // R4
    lamp_all_on_chk: assert (!(blank_ni && lamp_test_i) || lit == 7'h7f)
      else $error("lamp test violated");
    // R2
    invalid_off_chk: assert (!(blank_ni && !lamp_test_i && bcd_i > 4'd9) ||
                             (lit == 7'd0 && !suppress_o))
      else $error("invalid code not dark");
    // R6
    ripple_blank_chk: assert (!(blank_ni && !lamp_test_i && suppress_i && bcd_i == 4'd0) ||
                              (lit == 7'd0 && suppress_o))
      else $error("ripple blank violated");
    // R7
    nonzero_no_ripple_chk: assert (bcd_i == 4'd0 || !suppress_o)
      else $error("suppress out on nonzero digit");
    // R8
    no_ripple_in_chk: assert (suppress_i || !suppress_o)
      else $error("suppress out without suppress in");
  end
endmodule

bind bcd7_decoder bcd7_decoder_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .bcd_i       (bcd_i),
  .lamp_test_i (lamp_test_i),
  .blank_ni    (blank_ni),
  .suppress_i  (suppress_i),
  .seg_o       (seg_o),
  .suppress_o  (suppress_o)
);

// File: tb/sim_bcd7_decoder.sv
module sim_bcd7_decoder;
  localparam int NDIG = 5;
  localparam int NVEC = 22;
  localparam logic [6:0] P0 = 7'b1111110, P1 = 7'b0110000, P2 = 7'b1101101,
                         P3 = 7'b1111001, P4 = 7'b0110011, P5 = 7'b1011011,
                         P6 = 7'b1011111, P7 = 7'b1110000, P8 = 7'b1111111,
                         P9 = 7'b1111011;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] bcd;
  logic       lt, bn, si;
  logic [6:0] seg, seg_inv;
  logic       so, so_inv;

  bcd7_decoder #(.ACTIVE_LOW(1'b0)) u0 (
    .bcd_i(bcd), .lamp_test_i(lt), .blank_ni(bn), .suppress_i(si),
    .seg_o(seg), .suppress_o(so)
  );
  bcd7_decoder #(.ACTIVE_LOW(1'b1)) u_inv (
    .bcd_i(bcd), .lamp_test_i(lt), .blank_ni(bn), .suppress_i(si),
    .seg_o(seg_inv), .suppress_o(so_inv)
  );

  // five-digit chain, index NDIG-1 is most significant
  logic [3:0] ch_bcd [NDIG];
  logic [6:0] ch_seg [NDIG];
  logic       ch_so  [NDIG];
  logic       ch_si  [NDIG];

  for (genvar k = 0; k < NDIG; k++) begin : g_chain
    if (k == NDIG - 1) begin : g_top
      assign ch_si[k] = 1'b1;
    end else if (k == 0) begin : g_lsd
      assign ch_si[k] = 1'b0;
    end else begin : g_mid
      assign ch_si[k] = ch_so[k+1];
    end
    bcd7_decoder #(.ACTIVE_LOW(1'b0)) u_dig (
      .bcd_i(ch_bcd[k]), .lamp_test_i(1'b0), .blank_ni(1'b1),
      .suppress_i(ch_si[k]), .seg_o(ch_seg[k]), .suppress_o(ch_so[k])
    );
  end

  // {req, bcd, lamp, blank_n, suppress_in, seg, suppress_out}
  localparam logic [18:0] VEC [NVEC] = '{
    {4'd1, 4'd0, 3'b010, P0, 1'b0},      // R1 R8
    {4'd1, 4'd1, 3'b010, P1, 1'b0},      // R1
    {4'd1, 4'd2, 3'b010, P2, 1'b0},
    {4'd1, 4'd3, 3'b010, P3, 1'b0},
    {4'd1, 4'd4, 3'b010, P4, 1'b0},
    {4'd1, 4'd5, 3'b010, P5, 1'b0},
    {4'd1, 4'd6, 3'b010, P6, 1'b0},
    {4'd1, 4'd7, 3'b010, P7, 1'b0},
    {4'd1, 4'd8, 3'b010, P8, 1'b0},
    {4'd1, 4'd9, 3'b010, P9, 1'b0},
    {4'd2, 4'd10, 3'b010, 7'd0, 1'b0},   // R2
    {4'd2, 4'd15, 3'b011, 7'd0, 1'b0},   // R2 with suppress in
    {4'd4, 4'd3, 3'b110, 7'h7f, 1'b0},   // R4
    {4'd4, 4'd12, 3'b110, 7'h7f, 1'b0},  // R4 invalid code
    {4'd5, 4'd5, 3'b100, 7'd0, 1'b0},    // R5 beats lamp test
    {4'd5, 4'd0, 3'b001, 7'd0, 1'b0},    // R5 with ripple zero
    {4'd6, 4'd0, 3'b011, 7'd0, 1'b1},    // R6
    {4'd7, 4'd6, 3'b011, P6, 1'b0},      // R7
    {4'd7, 4'd1, 3'b011, P1, 1'b0},      // R7
    {4'd8, 4'd0, 3'b010, P0, 1'b0},      // R8
    {4'd9, 4'd0, 3'b111, 7'h7f, 1'b0},   // R9
    {4'd9, 4'd9, 3'b111, 7'h7f, 1'b0}    // R9 nonzero
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic run_chain(input int val, input logic [6:0] e4, input logic [6:0] e3,
                           input logic [6:0] e2, input logic [6:0] e1, input logic [6:0] e0);
    logic [6:0] exp [NDIG];
    exp[4] = e4; exp[3] = e3; exp[2] = e2; exp[1] = e1; exp[0] = e0;
    @(posedge clk);
    for (int k = 0; k < NDIG; k++) begin
      int p = 1;
      for (int j = 0; j < k; j++) p = p * 10;
      ch_bcd[k] = 4'((val / p) % 10);
    end
    @(negedge clk);
    for (int k = 0; k < NDIG; k++)
      check($sformatf("R10 value %05d digit %0d", val, k), {1'b0, ch_seg[k]}, {1'b0, exp[k]});
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bcd = '0; lt = 1'b0; bn = 1'b1; si = 1'b0;
    for (int k = 0; k < NDIG; k++) ch_bcd[k] = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state: digit 0 shown, no suppress out (R8)
    check("R8 idle", {so, seg}, {1'b0, P0});

    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk);
      {bcd, lt, bn, si} = {VEC[i][14:11], VEC[i][10:8]};
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VEC[i][18:15], i), {so, seg}, {VEC[i][0], VEC[i][7:1]});
      // R3 inverted polarity
      check($sformatf("R3 vec %0d", i), {so_inv, seg_inv}, {VEC[i][0], ~VEC[i][7:1]});
    end

    // R10 leading-zero suppression across the chain
    run_chain(1234,  7'd0, P1, P2, P3, P4);
    run_chain(0,     7'd0, 7'd0, 7'd0, 7'd0, P0);
    run_chain(700,   7'd0, 7'd0, P7, P0, P0);
    run_chain(10000, P1, P0, P0, P0, P0);
    run_chain(5,     7'd0, 7'd0, 7'd0, 7'd0, P5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule